// File: doc/BRIEF.md
# Four-Channel Converter Control Register File

This block is the register file that sits between the bus-side controller of a four-channel analog-to-digital converter and the converter itself. It holds two 8-byte pages: a read-out page with one 16-bit result per channel and a control/status page with one control byte and one status byte per channel. The bus-side controller reads and writes single bytes through a byte-wide port. The converter delivers a finished conversion through a second port: the channel index, the raw 16-bit value, the resolution it used and the outcome of its comparison against the high and low thresholds.

The register file stores each result MSB-aligned, with the bits below the used resolution forced to zero. It updates the per-channel high and low alarm flags on each conversion. It drives an open-drain pull-down enable for every channel whose output is enabled and driven low. It also raises a request to take part in the conditional search. That request is raised whenever the shared power-on flag is set, or whenever any channel has an alarm flag set together with its matching enable. Reads return the stored values combinationally in the same cycle. Writes and conversions take effect at the next rising clock edge.

Top module: `adcrf_top`

## Requirements
- R1: After reset, every read-out byte reads 00h, every control byte reads 08h, every status byte reads 8Ch, no drain output is active and search_req is 1.
- R2: Channel n's result is read at byte address 2n (bits 7:0) and 2n+1 (bits 15:8). Channel 0 is at address 00h.
- R3: A conversion with resolution code r between 1 and 15 stores the top r bits of the raw value (bits 15 down to 16-r) and zeros below them. Code 0 stores all 16 bits.
- R4: The control byte at 08h+2n reads {OE, OC, 0, 0, RC[3:0]}. The status byte at 09h+2n reads {POR, 0, AFH, AFL, AEH, AEL, 0, IR}. The bits shown as 0 read 0 whatever was written.
- R5: drain_on[n] is 1 exactly when OE (control bit 7) is 1 and OC (control bit 6) is 0.
- R6: A conversion sets AFH to the high-compare input and AFL to the low-compare input, so a conversion with neither compare set clears both flags.
- R7: A host write to a status byte clears AFH (bit 5) or AFL (bit 4) when that bit is written 0 and leaves it unchanged when it is written 1. If a conversion on the same channel arrives in the same cycle, the conversion's flag values win.
- R8: search_req equals POR OR, over all channels, (AFH AND AEH) OR (AFL AND AEL).
- R9: POR is a single device-wide bit. A write to any channel's status byte sets it to the written bit 7, and every status byte reads back that one value.
- R10: Reads of addresses 10h and above return 00h. Host writes to the read-out page or to addresses 10h and above change nothing.
- R11: A conversion updates the result whatever the state of OE and OC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| cv_valid | input | 1 | Converter delivers a result this cycle |
| cv_ch | input | 2 | Channel index of the delivered result |
| cv_raw | input | 16 | Raw MSB-aligned conversion value |
| cv_res | input | 4 | Resolution code used (0 means 16 bits) |
| cv_above | input | 1 | Result lies above the high threshold |
| cv_below | input | 1 | Result lies below the low threshold |
| drain_on | output | 4 | Per-channel open-drain pull-down enable |
| search_req | output | 1 | Participate in the conditional search |

## Verification
Every cycle, the assertions check the following. Reserved status and control bits read zero, and out-of-range reads return zero. A set POR always forces search_req. A conversion that reports no compare leaves both alarm flags clear. A host write that zeroes a flag clears it. The read-out page holds its value while no conversion arrives. A single POR write is visible at once. The resolution masking of arbitrary raw values can only be shown by the bench's scenarios, which compare against a reference model. The same holds for the byte placement of results, the same-cycle precedence between host writes and conversions, and the sharing of POR across all four status bytes.

// File: rtl/adcrf_pkg.sv
package adcrf_pkg;

    localparam int RES_W  = 16;
    localparam int CODE_W = 4;

    typedef struct packed {
        logic              oe;
        logic              oc;
        logic [CODE_W-1:0] rc;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{oe: 1'b0, oc: 1'b0, rc: 4'h8};

    // Reset state of the per-channel status bits (AEH, AEL set; flags, IR clear)
    localparam logic AEH_RST = 1'b1;
    localparam logic AEL_RST = 1'b1;

    // Keep the top bits selected by the resolution code; code 0 keeps all 16
    function automatic logic [RES_W-1:0] res_mask(input logic [CODE_W-1:0] code);
        logic [4:0] nbits;
        nbits = (code == '0) ? 5'd16 : {1'b0, code};
        return {RES_W{1'b1}} << (5'd16 - nbits);
    endfunction

    function automatic logic [7:0] pack_ctrl(input ctrl_t c);
        return {c.oe, c.oc, 2'b00, c.rc};
    endfunction

endpackage

// File: rtl/adcrf_channel.sv
module adcrf_channel
    import adcrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ctrl_we,
    input  logic              host_stat_we,
    input  logic [7:0]        wdata,
    input  logic              cv_we,
    input  logic [RES_W-1:0]  cv_raw,
    input  logic [CODE_W-1:0] cv_res,
    input  logic              cv_above,
    input  logic              cv_below,
    output logic [RES_W-1:0]  result,
    output logic [7:0]        ctrl_byte,
    output logic [7:0]        stat_byte,
    output logic              drain_on,
    output logic              alarm_hit
);

    ctrl_t ctrl_q;
    logic  aeh_q, ael_q, afh_q, afl_q, ir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            ctrl_q <= CTRL_RST;
            aeh_q  <= AEH_RST;
            ael_q  <= AEL_RST;
            afh_q  <= 1'b0;
            afl_q  <= 1'b0;
            ir_q   <= 1'b0;
        end else begin
            if (host_ctrl_we) begin
                ctrl_q <= '{oe: wdata[7], oc: wdata[6], rc: wdata[3:0]};
            end
            if (host_stat_we) begin
                aeh_q <= wdata[3];
                ael_q <= wdata[2];
                ir_q  <= wdata[0];
                afh_q <= afh_q & wdata[5];
                afl_q <= afl_q & wdata[4];
            end
            // A conversion overrides a same-cycle host flag write
            if (cv_we) begin
                result <= cv_raw & res_mask(cv_res);
                afh_q  <= cv_above;
                afl_q  <= cv_below;
            end
        end
    end

    always_comb begin
        ctrl_byte = pack_ctrl(ctrl_q);
        stat_byte = {1'b0, 1'b0, afh_q, afl_q, aeh_q, ael_q, 1'b0, ir_q};
        drain_on  = ctrl_q.oe & ~ctrl_q.oc;
        alarm_hit = (afh_q & aeh_q) | (afl_q & ael_q);
    end

    AST_FLAGS_CLEAR_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cv_we && !cv_above && !cv_below |=> stat_byte[5:4] == 2'b00); // R6
    AST_HOST_CLEARS_AFH: assert property (@(posedge clk) disable iff (!rst_n)
        host_stat_we && !wdata[5] && !cv_we |=> !stat_byte[5]); // R7
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cv_we |=> $stable(result)); // R10
    AST_RES8_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cv_we && cv_res == 4'd8 |=> result[7:0] == 8'h00); // R3
    AST_DRAIN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ctrl_we && wdata[7:6] == 2'b10 |=> drain_on); // R5
    AST_DRAIN_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ctrl_we && !wdata[7] |=> !drain_on); // R5

endmodule

// File: rtl/adcrf_por.sv
module adcrf_por (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_we_any,
    input  logic wbit,
    output logic por
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por <= 1'b1;
        end else if (stat_we_any) begin
            por <= wbit;
        end
    end

    AST_POR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we_any |=> por == $past(wbit)); // R9

endmodule

// File: rtl/adcrf_rdmux.sv
module adcrf_rdmux
    import adcrf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][RES_W-1:0]  results,
    input  logic [NUM_CH-1:0][7:0]        ctrl_bytes,
    input  logic [NUM_CH-1:0][7:0]        stat_bytes,
    input  logic                          por,
    output logic [7:0]                    rdata
);

    localparam int CH_W    = $clog2(NUM_CH);
    localparam int PG_SIZE = 2 * NUM_CH;

    logic [CH_W-1:0] ch;

    always_comb begin
        rdata = 8'h00;
        ch    = addr[CH_W:1];
        if (addr < ADDR_W'(PG_SIZE)) begin
            rdata = addr[0] ? results[ch][15:8] : results[ch][7:0];
        end else if (addr < ADDR_W'(2 * PG_SIZE)) begin
            rdata = addr[0] ? {por, stat_bytes[ch][6:0]} : ctrl_bytes[ch];
        end
    end

endmodule

// File: rtl/adcrf_top.sv
module adcrf_top
    import adcrf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              cv_valid,
    input  logic [CH_W-1:0]   cv_ch,
    input  logic [RES_W-1:0]  cv_raw,
    input  logic [CODE_W-1:0] cv_res,
    input  logic              cv_above,
    input  logic              cv_below,
    output logic [NUM_CH-1:0] drain_on,
    output logic              search_req
);

    localparam int PG_SIZE = 2 * NUM_CH;

    logic                         pg1_sel;
    logic                         pg1_we;
    logic [CH_W-1:0]              wr_ch;
    logic [NUM_CH-1:0]            ctrl_we, stat_we, cv_we, alarm_hit;
    logic [NUM_CH-1:0][RES_W-1:0] results;
    logic [NUM_CH-1:0][7:0]       ctrl_bytes, stat_bytes;
    logic                         por;

    assign pg1_sel = (host_addr >= ADDR_W'(PG_SIZE)) && (host_addr < ADDR_W'(2 * PG_SIZE));
    assign pg1_we  = host_we && pg1_sel;
    assign wr_ch   = host_addr[CH_W:1];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign ctrl_we[n] = pg1_we && (wr_ch == CH_W'(n)) && !host_addr[0];
        assign stat_we[n] = pg1_we && (wr_ch == CH_W'(n)) && host_addr[0];
        assign cv_we[n]   = cv_valid && (cv_ch == CH_W'(n));

        adcrf_channel u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .host_ctrl_we (ctrl_we[n]),
            .host_stat_we (stat_we[n]),
            .wdata        (host_wdata),
            .cv_we        (cv_we[n]),
            .cv_raw       (cv_raw),
            .cv_res       (cv_res),
            .cv_above     (cv_above),
            .cv_below     (cv_below),
            .result       (results[n]),
            .ctrl_byte    (ctrl_bytes[n]),
            .stat_byte    (stat_bytes[n]),
            .drain_on     (drain_on[n]),
            .alarm_hit    (alarm_hit[n])
        );
    end

    adcrf_por u_por (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_we_any (|stat_we),
        .wbit        (host_wdata[7]),
        .por         (por)
    );

    adcrf_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
        .addr       (host_addr),
        .results    (results),
        .ctrl_bytes (ctrl_bytes),
        .stat_bytes (stat_bytes),
        .por        (por),
        .rdata      (host_rdata)
    );

    assign search_req = por | (|alarm_hit);

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr >= ADDR_W'(2 * PG_SIZE) |-> host_rdata == 8'h00); // R10
    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pg1_sel && !host_addr[0] |-> host_rdata[5:4] == 2'b00); // R4
    AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pg1_sel && host_addr[0] |-> host_rdata[6] == 1'b0 && host_rdata[1] == 1'b0); // R4
    AST_POR_FORCES_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        por |-> search_req); // R8

endmodule

// File: tb/sim_adcrf_top.sv
module sim_adcrf_top;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        cv_valid = 1'b0;
    logic [1:0]  cv_ch = '0;
    logic [15:0] cv_raw = '0;
    logic [3:0]  cv_res = '0;
    logic        cv_above = 1'b0;
    logic        cv_below = 1'b0;
    logic [3:0]  drain_on;
    logic        search_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model
    logic [15:0] m_res [4];
    logic        m_oe [4], m_oc [4], m_aeh [4], m_ael [4], m_afh [4], m_afl [4], m_ir [4];
    logic [3:0]  m_rc [4];
    logic        m_por;

    adcrf_top u0 (.*);

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_mask(input logic [3:0] code);
        int keep;
        logic [15:0] m;
        keep = (code == 0) ? 16 : int'(code);
        m = '0;
        for (int i = 0; i < 16; i++) if (i >= 16 - keep) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        int c;
        c = int'(a[2:1]);
        if (a < 8) return a[0] ? m_res[c][15:8] : m_res[c][7:0];
        if (a < 16) return a[0] ? {m_por, 1'b0, m_afh[c], m_afl[c], m_aeh[c], m_ael[c], 1'b0, m_ir[c]}
                                 : {m_oe[c], m_oc[c], 2'b00, m_rc[c]};
        return 8'h00;
    endfunction

    function automatic logic exp_search();
        logic s;
        s = m_por;
        for (int c = 0; c < 4; c++) s |= (m_afh[c] & m_aeh[c]) | (m_afl[c] & m_ael[c]);
        return s;
    endfunction

    function automatic logic [3:0] exp_drain();
        logic [3:0] d;
        for (int c = 0; c < 4; c++) d[c] = m_oe[c] & ~m_oc[c];
        return d;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_res[c] = '0; m_oe[c] = 0; m_oc[c] = 0; m_rc[c] = 4'h8;
            m_aeh[c] = 1; m_ael[c] = 1; m_afh[c] = 0; m_afl[c] = 0; m_ir[c] = 0;
        end
        m_por = 1;
    endtask

    task automatic model_host(input logic [7:0] a, input logic [7:0] d);
        int c;
        c = int'(a[2:1]);
        if (a >= 8 && a < 16) begin
            if (!a[0]) begin
                m_oe[c] = d[7]; m_oc[c] = d[6]; m_rc[c] = d[3:0];
            end else begin
                m_por = d[7]; m_afh[c] &= d[5]; m_afl[c] &= d[4];
                m_aeh[c] = d[3]; m_ael[c] = d[2]; m_ir[c] = d[0];
            end
        end
    endtask

    task automatic model_conv(input int c, input logic [15:0] raw, input logic [3:0] r,
                              input logic ab, input logic bl);
        m_res[c] = raw & exp_mask(r);
        m_afh[c] = ab;
        m_afl[c] = bl;
    endtask

    // Drive one cycle with an optional host write and an optional conversion
    task automatic step(input bit hw, input logic [7:0] a, input logic [7:0] d,
                        input bit cw, input int c, input logic [15:0] raw,
                        input logic [3:0] r, input logic ab, input logic bl);
        @(negedge clk);
        host_we = hw; host_addr = a; host_wdata = d;
        cv_valid = cw; cv_ch = 2'(c); cv_raw = raw; cv_res = r; cv_above = ab; cv_below = bl;
        @(negedge clk);
        host_we = 0; cv_valid = 0;
        if (hw) model_host(a, d);
        if (cw) model_conv(c, raw, r, ab, bl);
    endtask

    task automatic rd_check(input logic [7:0] a, input string tag);
        host_addr = a;
        #1;
        check(tag, {8'h00, host_rdata}, {8'h00, exp_byte(a)});
    endtask

    task automatic sweep();
        for (int a = 0; a < 8; a++) rd_check(8'(a), "R2_R3 readout");
        for (int a = 8; a < 16; a++) rd_check(8'(a), "R4_R9 ctrl/status");
        check("R5 drain_on", {12'h0, drain_on}, {12'h0, exp_drain()});
        check("R8 search_req", {15'h0, search_req}, {15'h0, exp_search()});
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_2450));
        model_reset();
        #(PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 16; a++) rd_check(8'(a), "R1 reset value");
        check("R1 reset search_req", {15'h0, search_req}, 16'h1);
        check("R1 reset drain_on", {12'h0, drain_on}, 16'h0);

        // R3 resolution corners
        step(0, 0, 0, 1, 0, 16'hFFFF, 4'd0, 0, 0);
        rd_check(8'h00, "R3 code0 low"); rd_check(8'h01, "R3 code0 high");
        step(0, 0, 0, 1, 1, 16'hFFFF, 4'd1, 0, 0);
        rd_check(8'h02, "R3 code1 low"); rd_check(8'h03, "R3 code1 high");
        step(0, 0, 0, 1, 3, 16'hABCD, 4'd15, 0, 0);
        rd_check(8'h06, "R3 code15 low");

        // R4 reserved bits written 1 read 0
        step(1, 8'h08, 8'hFF, 0, 0, 0, 0, 0, 0);
        rd_check(8'h08, "R4 ctrl reserved");
        step(1, 8'h09, 8'hFF, 0, 0, 0, 0, 0, 0);
        rd_check(8'h09, "R4 status reserved");

        // R5 output control with OE=1, OC=0; R11 conversion still lands
        step(1, 8'h0C, 8'h80, 0, 0, 0, 0, 0, 0);
        check("R5 drain on ch2", {15'h0, drain_on[2]}, 16'h1);
        step(0, 0, 0, 1, 2, 16'h1234, 4'd0, 0, 0);
        rd_check(8'h04, "R11 conversion with output on");
        rd_check(8'h05, "R11 conversion with output on");

        // R6 set then quiet conversion clears
        step(0, 0, 0, 1, 1, 16'h8000, 4'd12, 1, 1);
        rd_check(8'h0B, "R6 flags set");
        step(0, 0, 0, 1, 1, 16'h8000, 4'd12, 0, 0);
        rd_check(8'h0B, "R6 flags cleared");

        // R7 host clear, write-1 no set, and same-cycle precedence
        step(0, 0, 0, 1, 0, 16'h4000, 4'd10, 1, 1);
        step(1, 8'h09, 8'h1C, 0, 0, 0, 0, 0, 0);
        rd_check(8'h09, "R7 AFH cleared AFL kept");
        step(1, 8'h09, 8'h3C, 0, 0, 0, 0, 0, 0);
        rd_check(8'h09, "R7 write 1 does not set");
        step(1, 8'h09, 8'h0C, 1, 0, 16'h0100, 4'd0, 1, 0);
        rd_check(8'h09, "R7 conversion wins");

        // R9 POR shared: clear through ch3, then set through ch1
        step(1, 8'h0F, 8'h0C, 0, 0, 0, 0, 0, 0);
        rd_check(8'h09, "R9 POR shared clear");
        step(1, 8'h0B, 8'h80, 0, 0, 0, 0, 0, 0);
        rd_check(8'h0D, "R9 POR shared set");

        // R10 out of range reads and ignored writes
        step(1, 8'h02, 8'h5A, 0, 0, 0, 0, 0, 0);
        rd_check(8'h02, "R10 page0 write ignored");
        step(1, 8'h10, 8'hFF, 0, 0, 0, 0, 0, 0);
        rd_check(8'h10, "R10 oor read");
        rd_check(8'hFF, "R10 oor read");
        sweep();

        // Random mix
        for (int i = 0; i < 600; i++) begin
            bit hw, cw;
            logic [7:0] a;
            hw = ($urandom % 3) != 0;
            cw = ($urandom % 2) != 0;
            a = (($urandom % 4) == 0) ? 8'($urandom) : 8'(8 + ($urandom % 8));
            step(hw, a, 8'($urandom), cw, int'($urandom % 4), 16'($urandom),
                 4'($urandom), 1'($urandom), 1'($urandom));
            if ((i % 6) == 5) sweep();
        end
        sweep();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule